// File: doc/BRIEF.md
# Program Counter Sequencer with Three-Entry Return Stack

This block holds the 12-bit instruction address of a small 4-bit processor whose program memory is split into 256-word pages. Each cycle the instruction decoder presents one request code and, when needed, a target field. The sequencer then forms the next address. The request can be a step of one or two words, a full-width jump, a subroutine call or return, a short jump within a page, or an indirect jump within a page. The decoder is expected to have evaluated any condition already, so a jump that is not taken arrives as a plain two-word step.

Return addresses are held in a ring of three slots with a 2-bit pointer. A call stores the address of the word that follows the two-word call and advances the pointer. A return steps the pointer back and resumes from the slot it lands on. The ring never reports overflow or underflow. A fourth nested call reuses the slot of the oldest entry, and a return on an empty ring wraps the pointer in the same way. A combinational output gives the indirect table address (the page of the next word joined with the supplied low byte), so that an indirect fetch can read program memory while the counter simply steps by one.

Top module: `addr_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, `pc` and `sp` read 0 and every saved return slot holds 0.
- R2: Op code 0 (hold) leaves `pc` and `sp` unchanged. Op 1 adds 1 to `pc` and op 2 adds 2. Both wrap modulo 4096, and `sp` stays the same.
- R3: Op 3 (jump) loads `pc` with `tgt_full` on the next clock edge, and `sp` does not change.
- R4: Op 4 (call) loads `pc` with `tgt_full`, saves `pc+2` (modulo 4096) in the slot indexed by `sp`, and moves `sp` to `(sp+1) mod 3`.
- R5: Op 5 (return) moves `sp` to `(sp+2) mod 3` and loads `pc` from the slot at that new index.
- R6: A fourth nested call overwrites the slot that held the oldest return address, raises no indication, and later returns deliver the newest addresses first.
- R7: Op 6 (short jump) loads `pc[7:0]` with `tgt_low` and `pc[11:8]` with bits 11:8 of `pc+2`. A jump placed on the last two words of a page therefore lands in the next page.
- R8: Op 7 (indirect jump) loads `pc[7:0]` with `tgt_low` and `pc[11:8]` with bits 11:8 of `pc+1`. An instruction on word 0xFF of a page therefore uses the next page.
- R9: `ind_addr` shows `{bits 11:8 of pc+1, tgt_low}` in the same cycle as its inputs. It does not depend on `op`.
- R10: A return issued with an empty ring (`sp`=0) wraps `sp` to 2 and resumes from slot 2 without any error indication.
- R11: `sp` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 3 | Request code: 0 hold, 1 step 1, 2 step 2, 3 jump, 4 call, 5 return, 6 short jump, 7 indirect jump |
| tgt_full | input | 12 | Full target address for jump and call |
| tgt_low | input | 8 | Low byte for short jump, indirect jump and indirect fetch |
| pc | output | 12 | Current program counter |
| sp | output | 2 | Return-ring pointer |
| ind_addr | output | 12 | Indirect table address for the current `pc` and `tgt_low` |

## Verification
`pc` and `sp` pass through exactly one register, so the result of an op presented in a cycle appears just after the following rising edge. `ind_addr` is combinational and is valid within the cycle in which its inputs are applied. The driver tags each expected `pc`/`sp` pair with the bench cycle in which it becomes due. The monitor compares only the entries whose cycle has arrived, and it samples shortly after the falling edge. The driver checks `ind_addr` a moment after it changes the inputs, before the next rising edge.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Request codes presented by the decoder each cycle
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP1 = 3'd1,
    OP_STEP2 = 3'd2,
    OP_JUMP  = 3'd3,
    OP_CALL  = 3'd4,
    OP_RET   = 3'd5,
    OP_SHORT = 3'd6,
    OP_INDJ  = 3'd7
  } pc_op_e;

  localparam int DEF_ADDR_W = 12;
  localparam int DEF_LOW_W  = 8;
  localparam int DEF_DEPTH  = 3;

endpackage

// File: rtl/pcs_next_calc.sv
module pcs_next_calc
  import pcs_pkg::*;
#(
  parameter int AW = DEF_ADDR_W,
  parameter int LW = DEF_LOW_W
) (
  input  pc_op_e        op,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt_full,
  input  logic [LW-1:0] tgt_low,
  input  logic [AW-1:0] pop_val,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] push_val,
  output logic [AW-1:0] ind_addr
);

  localparam int PW = AW - LW;

  // Advance an address by a number of words, wrapping at the top of memory
  function automatic logic [AW-1:0] add_words(input logic [AW-1:0] a, input int unsigned n);
    return a + AW'(n);
  endfunction

  // Join the page of one address with a low byte
  function automatic logic [AW-1:0] splice(input logic [AW-1:0] page_src,
                                           input logic [LW-1:0] low);
    logic [PW-1:0] page;
    page = page_src[AW-1:LW];
    return {page, low};
  endfunction

  logic [AW-1:0] plus1;
  logic [AW-1:0] plus2;

  assign plus1    = add_words(pc, 1);
  assign plus2    = add_words(pc, 2);
  assign push_val = plus2;
  assign ind_addr = splice(plus1, tgt_low);

  always_comb begin
    unique case (op)
      OP_HOLD:  pc_next = pc;
      OP_STEP1: pc_next = plus1;
      OP_STEP2: pc_next = plus2;
      OP_JUMP:  pc_next = tgt_full;
      OP_CALL:  pc_next = tgt_full;
      OP_RET:   pc_next = pop_val;
      OP_SHORT: pc_next = splice(plus2, tgt_low);
      OP_INDJ:  pc_next = splice(plus1, tgt_low);
      default:  pc_next = pc;
    endcase
  end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack
  import pcs_pkg::*;
#(
  parameter int AW    = DEF_ADDR_W,
  parameter int DEPTH = DEF_DEPTH,
  parameter int SPW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic           pop,
  input  logic [AW-1:0]  push_val,
  output logic [SPW-1:0] sp,
  output logic [AW-1:0]  pop_val
);

  localparam logic [SPW-1:0] LAST = SPW'(DEPTH - 1);

  function automatic logic [SPW-1:0] ring_inc(input logic [SPW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [SPW-1:0] ring_dec(input logic [SPW-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  logic [AW-1:0]  slot [DEPTH];
  logic [SPW-1:0] sp_back;

  assign sp_back = ring_dec(sp);

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)
          slot[g] <= '0;
        else if (push && sp == SPW'(g))
          slot[g] <= push_val;
      end
    end
  endgenerate

  always_comb begin
    pop_val = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_back == SPW'(i)) pop_val = slot[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sp <= '0;
    else if (push)
      sp <= ring_inc(sp);
    else if (pop)
      sp <= sp_back;
  end

endmodule

// File: rtl/addr_sequencer.sv
module addr_sequencer
  import pcs_pkg::*;
#(
  parameter int AW    = DEF_ADDR_W,
  parameter int LW    = DEF_LOW_W,
  parameter int DEPTH = DEF_DEPTH,
  parameter int SPW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op,
  input  logic [AW-1:0]  tgt_full,
  input  logic [LW-1:0]  tgt_low,
  output logic [AW-1:0]  pc,
  output logic [SPW-1:0] sp,
  output logic [AW-1:0]  ind_addr
);

  pc_op_e        op_q;
  logic          push_evt;
  logic          pop_evt;
  logic [AW-1:0] pc_next;
  logic [AW-1:0] push_val;
  logic [AW-1:0] pop_val;

  assign op_q     = pc_op_e'(op);
  assign push_evt = (op_q == OP_CALL);
  assign pop_evt  = (op_q == OP_RET);

  pcs_next_calc #(.AW(AW), .LW(LW)) u_calc (
    .op       (op_q),
    .pc       (pc),
    .tgt_full (tgt_full),
    .tgt_low  (tgt_low),
    .pop_val  (pop_val),
    .pc_next  (pc_next),
    .push_val (push_val),
    .ind_addr (ind_addr)
  );

  pcs_ret_stack #(.AW(AW), .DEPTH(DEPTH), .SPW(SPW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .pop      (pop_evt),
    .push_val (push_val),
    .sp       (sp),
    .pop_val  (pop_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

endmodule

// File: rtl/addr_sequencer_chk.sv
module addr_sequencer_chk
  import pcs_pkg::*;
#(
  parameter int AW    = DEF_ADDR_W,
  parameter int LW    = DEF_LOW_W,
  parameter int DEPTH = DEF_DEPTH,
  parameter int SPW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     op,
  input logic [AW-1:0]  tgt_full,
  input logic [LW-1:0]  tgt_low,
  input logic [AW-1:0]  pc,
  input logic [SPW-1:0] sp,
  input logic [AW-1:0]  ind_addr,
  input logic           push_evt,
  input logic           pop_evt
);

  logic [AW-1:0] pc_a1;
  logic [AW-1:0] pc_a2;
  assign pc_a1 = pc + AW'(1);
  assign pc_a2 = pc + AW'(2);

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> ($stable(pc) && $stable(sp)));

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP1) |=> (pc == $past(pc_a1)));

  // R3
  full_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP) |=> (pc == $past(tgt_full) && sp == $past(sp)));

  // R4
  call_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (sp == (($past(sp) == SPW'(DEPTH - 1)) ? '0 : $past(sp) + 1'b1)
                  && pc == $past(tgt_full)));

  // R5
  ret_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> (sp == (($past(sp) == '0) ? SPW'(DEPTH - 1) : $past(sp) - 1'b1)));

  // R7
  short_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHORT) |=> (pc[LW-1:0] == $past(tgt_low)
                          && pc[AW-1:LW] == $past(pc_a2[AW-1:LW])));

  // R8
  ind_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INDJ) |=> (pc[LW-1:0] == $past(tgt_low)
                         && pc[AW-1:LW] == $past(pc_a1[AW-1:LW])));

  // R9
  ind_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_addr[LW-1:0] == tgt_low && ind_addr[AW-1:LW] == pc_a1[AW-1:LW]));

  // R11
  sp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sp) < DEPTH));

endmodule

bind addr_sequencer addr_sequencer_chk #(
  .AW(AW), .LW(LW), .DEPTH(DEPTH), .SPW(SPW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op),
  .tgt_full (tgt_full),
  .tgt_low  (tgt_low),
  .pc       (pc),
  .sp       (sp),
  .ind_addr (ind_addr),
  .push_evt (push_evt),
  .pop_evt  (pop_evt)
);

// File: tb/addr_sequencer_test.sv
module addr_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [11:0] tgt_full = '0;
  logic [7:0]  tgt_low = '0;
  logic [11:0] pc;
  logic [1:0]  sp;
  logic [11:0] ind_addr;

  addr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .op(op), .tgt_full(tgt_full),
    .tgt_low(tgt_low), .pc(pc), .sp(sp), .ind_addr(ind_addr)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          due;
    logic [11:0] pc;
    int          sp;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [11:0] m_pc;
  int          m_sp;
  logic [11:0] m_ring [3];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every expected item whose cycle has come
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (pc !== it.pc || int'(sp) != it.sp) begin
        n_bad++;
        $display("FAIL %s: pc=%h sp=%0d expected pc=%h sp=%0d",
                 it.tag, pc, sp, it.pc, it.sp);
      end
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; op = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_sp = 0;
    for (int i = 0; i < 3; i++) m_ring[i] = '0;
    #1;
    n_chk++;
    if (pc !== 12'h000 || sp !== 2'd0) begin
      n_bad++;
      $display("FAIL %s: pc=%h sp=%0d expected pc=000 sp=0", tag, pc, sp);
    end
  endtask

  // Driver: applies one request, checks the indirect address, queues the result
  task automatic drive(input logic [2:0] o, input logic [11:0] f,
                       input logic [7:0] l, input string tag);
    logic [11:0] nx1, nx2, want_ind;
    exp_t it;
    @(negedge clk);
    op = o; tgt_full = f; tgt_low = l;
    nx1 = m_pc + 12'd1;
    nx2 = m_pc + 12'd2;
    want_ind = {nx1[11:8], l};
    #1;
    n_chk++;
    if (ind_addr !== want_ind) begin
      n_bad++;
      $display("FAIL R9 (%s): ind_addr=%h expected %h", tag, ind_addr, want_ind);
    end
    case (o)
      3'd1: m_pc = nx1;
      3'd2: m_pc = nx2;
      3'd3: m_pc = f;
      3'd4: begin m_ring[m_sp] = nx2; m_sp = (m_sp + 1) % 3; m_pc = f; end
      3'd5: begin m_sp = (m_sp + 2) % 3; m_pc = m_ring[m_sp]; end
      3'd6: m_pc = {nx2[11:8], l};
      3'd7: m_pc = {nx1[11:8], l};
      default: ;
    endcase
    it.due = cyc + 1; it.pc = m_pc; it.sp = m_sp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    do_reset("R1 reset");
    drive(3'd1, '0, '0, "R2 step1 a");
    drive(3'd1, '0, '0, "R2 step1 b");
    drive(3'd2, '0, '0, "R2 step2");
    drive(3'd0, 12'hABC, 8'h5A, "R2 hold");
    drive(3'd3, 12'hFFE, '0, "R3 jump");
    drive(3'd1, '0, '0, "R2 step to top");
    drive(3'd1, '0, '0, "R2 wrap step1");
    drive(3'd3, 12'hFFF, '0, "R3 jump top");
    drive(3'd2, '0, '0, "R2 wrap step2");
    drive(3'd3, 12'h0FD, '0, "R3 jump 0FD");
    drive(3'd6, '0, 8'h40, "R7 short same page");
    drive(3'd3, 12'h0FE, '0, "R3 jump 0FE");
    drive(3'd6, '0, 8'h40, "R7 short next page");
    drive(3'd3, 12'h250, '0, "R3 jump 250");
    drive(3'd1, '0, 8'h33, "R9 fetch addr mid page");
    drive(3'd3, 12'h2FF, '0, "R3 jump 2FF");
    drive(3'd7, '0, 8'h33, "R8 indirect last word");
    drive(3'd7, '0, 8'h90, "R8 indirect mid page");
    drive(3'd3, 12'h100, '0, "R3 jump 100");
    drive(3'd4, 12'h200, '0, "R4 call 1");
    drive(3'd4, 12'h300, '0, "R4 call 2");
    drive(3'd4, 12'h400, '0, "R4 call 3 wraps sp");
    drive(3'd4, 12'h500, '0, "R6 call 4 overwrites");
    drive(3'd5, '0, '0, "R5 return newest");
    drive(3'd5, '0, '0, "R5 return 2");
    drive(3'd5, '0, '0, "R5 return 3");
    drive(3'd5, '0, '0, "R6 return sees overwrite");
    drive(3'd0, '0, '0, "R2 hold after returns");
    repeat (3) @(negedge clk);
    do_reset("R1 second reset");
    drive(3'd5, '0, '0, "R10 empty return");
    drive(3'd5, '0, '0, "R10 second empty return");
    drive(3'd3, 12'h7F0, '0, "R3 jump 7F0");
    drive(3'd4, 12'h010, '0, "R4 call after wrap");
    drive(3'd5, '0, '0, "R5 return after wrap");
    drive(3'd0, '0, '0, "R2 final hold");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end

endmodule